// File: doc/BRIEF.md
# Boundary-scan test access port

This block is the serial test port of a memory device. It is clocked by the test clock and steered by the mode-select input through the standard sixteen-state test controller. A three-bit instruction register chooses one of three data registers to sit between the serial input and the serial output: a one-bit bypass cell, a 32-bit identification word, or a 70-bit sampling register. The sampling register takes a snapshot of the device pins. One instruction group also raises a control that holds the device data drivers in high impedance while the pins are sampled.

There is no test-reset pin. The controller starts in Test-Logic-Reset when the power-on reset from the supply monitor is low, and it can always be brought back there by holding the mode-select input high for five test clocks. The serial output is driven from a register that changes on the falling test-clock edge. A separate enable, which the pad uses, is high only while a register is being shifted. Pad cells are outside the block, and the block never drives internal memory data into the scan path.

Top module: `scan_tap`

## Requirements
- R1: While por_n is low and after it rises, the controller is in Test-Logic-Reset, the instruction is IDCODE (3'b001), tdo_oe is 0 and out_hiz is 0. A data scan made straight after power-up therefore returns the identification word.
- R2: The controller follows the standard sixteen-state transition graph. Five consecutive rising edges with tms high reach Test-Logic-Reset from any state. On each rising edge spent in Test-Logic-Reset the instruction is set to IDCODE.
- R3: The instruction register is 3 bits and shifts in Shift-IR with tdi entering at bit 2 and bit 0 leaving first. In Capture-IR it loads 3'b001, so the first three bits shifted out are 1, 0, 0.
- R4: Opcodes 3'b000 and 3'b010 select the sampling register with the outputs held in high impedance. 3'b100 selects the sampling register with no effect on the outputs. 3'b001 selects the identification register. 3'b011, 3'b101, 3'b110 and 3'b111 select bypass. A shifted opcode takes effect only on the rising edge that leaves Update-IR.
- R5: out_hiz is 1 exactly while the current instruction is 3'b000 or 3'b010.
- R6: The identification register holds {revision[31:28], configuration[27:18], vendor field[17:12], manufacturer code[11:1], 1'b1}. It is loaded in Capture-DR and shifted out bit 0 first, with tdi entering at bit 31.
- R7: The bypass register is one bit. It is cleared to 0 in Capture-DR and loads tdi on each Shift-DR edge, so scanned data comes out one clock late behind a leading 0.
- R8: The 70-bit sampling register loads pin_cap on the Capture-DR rising edge and shifts bit 0 out first, with tdi entering at bit 69. Pin changes after the capture have no effect on the scanned data until the next Capture-DR.
- R9: tdo and tdo_oe change only on falling edges of tck. After the falling edge, tdo_oe is 1 exactly when the controller is in Shift-IR or Shift-DR, and tdo shows bit 0 of the register being shifted.
- R10: Passing through Exit1-DR, Pause-DR and Exit2-DR back into Shift-DR leaves the register contents unchanged, so the shift resumes at the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset from the supply monitor, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge of tck |
| tdi | input | 1 | Serial data in, sampled on the rising edge of tck |
| pin_cap | input | BSR_W | Pin values taken by the sampling register in Capture-DR |
| tdo | output | 1 | Serial data out, updated on the falling edge of tck |
| tdo_oe | output | 1 | Enable for the tdo pad driver |
| out_hiz | output | 1 | Forces the device data outputs to high impedance |

## Verification
A new instruction changes out_hiz and the selected register on the rising edge that leaves Update-IR. A captured register shows its bit 0 on tdo after the falling edge that follows the Capture-DR rising edge, and each later bit appears one tck period after the one before. The bench changes tms and tdi only while tck is low and reads tdo, tdo_oe and out_hiz one nanosecond after a falling edge. One directed check also reads tdo just after a rising edge to confirm that the value has not yet moved. Expected scan images are built in the bench from the pin pattern, the identification fields and the tdi pattern, with the one-bit delay of bypass and the register length taken into account.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] IR_IDCODE      = 3'b001;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BSR, DR_ID, DR_BYP
  } dr_sel_e;

  function automatic dr_sel_e decode_sel(input logic [IR_W-1:0] op);
    case (op)
      3'b000, 3'b010, 3'b100: decode_sel = DR_BSR;
      3'b001:                 decode_sel = DR_ID;
      default:                decode_sel = DR_BYP;
    endcase
  endfunction

  function automatic logic decode_hiz(input logic [IR_W-1:0] op);
    decode_hiz = (op == 3'b000) || (op == 3'b010);
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  tap_next = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   tap_next = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: tap_next = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: tap_next = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: tap_next = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: tap_next = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: tap_next = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: tap_next = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: tap_next = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: tap_next = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: tap_next = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: tap_next = m ? ST_SEL_DR : ST_IDLE;
      default:   tap_next = ST_RESET;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  // shift stage: capture pattern, then serial shift toward bit 0
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= IR_CAPTURE_PAT;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAPTURE_PAT;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:   ir_sr <= ir_sr;
      endcase
    end
  end

  // held instruction: changes only in Test-Logic-Reset and Update-IR
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q <= IR_IDCODE;
    end else begin
      case (state)
        ST_RESET:  ir_q <= IR_IDCODE;
        ST_UPD_IR: ir_q <= ir_sr;
        default:   ir_q <= ir_q;
      endcase
    end
  end

  assign ir_so = ir_sr[0];

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              BSR_W   = 70,
  parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  dr_sel_e          sel,
  input  logic [BSR_W-1:0] pin_cap,
  output logic             dr_so
);

  logic             cap_en;
  logic             sh_en;
  logic             byp_q;
  logic [ID_W-1:0]  id_sr;
  logic [BSR_W-1:0] bsr;
  logic [BSR_W-1:0] bsr_nxt;

  assign cap_en = (state == ST_CAP_DR);
  assign sh_en  = (state == ST_SH_DR);

  // one-bit bypass path
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                           byp_q <= 1'b0;
    else if (sel == DR_BYP && cap_en)     byp_q <= 1'b0;
    else if (sel == DR_BYP && sh_en)      byp_q <= tdi;
  end

  // identification word
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                           id_sr <= ID_WORD;
    else if (sel == DR_ID && cap_en)      id_sr <= ID_WORD;
    else if (sel == DR_ID && sh_en)       id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  // sampling register: serial neighbour per cell
  for (genvar i = 0; i < BSR_W; i++) begin : g_bsr
    if (i == BSR_W - 1) begin : g_head
      assign bsr_nxt[i] = tdi;
    end else begin : g_body
      assign bsr_nxt[i] = bsr[i+1];
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                           bsr <= '0;
    else if (sel == DR_BSR && cap_en)     bsr <= pin_cap;
    else if (sel == DR_BSR && sh_en)      bsr <= bsr_nxt;
  end

  always_comb begin
    case (sel)
      DR_BSR:  dr_so = bsr[0];
      DR_ID:   dr_so = id_sr[0];
      default: dr_so = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W   = 70,
  parameter logic [3:0]  ID_REV  = 4'h2,
  parameter logic [9:0]  ID_CFG  = 10'h0C5,
  parameter logic [5:0]  ID_VEND = 6'h00,
  parameter logic [10:0] ID_MFR  = 11'h04E
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pin_cap,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             out_hiz
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  logic            dr_so;
  dr_sel_e         dr_sel;
  logic            so_mux;
  logic            shifting;
  logic            tdo_q;
  logic            oe_q;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .tck   (tck),
    .por_n (por_n),
    .tdi   (tdi),
    .state (state),
    .ir_q  (ir_q),
    .ir_so (ir_so)
  );

  assign dr_sel  = decode_sel(ir_q);
  assign out_hiz = decode_hiz(ir_q);

  scan_tap_dr #(
    .BSR_W   (BSR_W),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck     (tck),
    .por_n   (por_n),
    .tdi     (tdi),
    .state   (state),
    .sel     (dr_sel),
    .pin_cap (pin_cap),
    .dr_so   (dr_so)
  );

  assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_comb begin
    case (state)
      ST_SH_IR: so_mux = ir_so;
      ST_SH_DR: so_mux = dr_so;
      default:  so_mux = 1'b0;
    endcase
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= so_mux;
      oe_q  <= shifting;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic            out_hiz,
  input logic            tdo_oe
);

  logic       past_ok;
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)             ones_cnt <= '0;
    else if (!tms)          ones_cnt <= '0;
    else if (ones_cnt != 7) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
    ones_cnt >= 3'd5 |-> state == ST_RESET); // R2

  AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!por_n || !past_ok)
    $past(state) == ST_RESET |-> ir_q == IR_IDCODE); // R2

  AST_IR_HELD_OUTSIDE_UPDATE: assert property (@(posedge tck) disable iff (!por_n || !past_ok)
    !($past(state) == ST_UPD_IR || $past(state) == ST_RESET) |-> $stable(ir_q)); // R4

  AST_HIZ_RISES_AT_UPDATE: assert property (@(posedge tck) disable iff (!por_n || !past_ok)
    $rose(out_hiz) |-> $past(state) == ST_UPD_IR); // R5

  AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR)); // R9

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck     (tck),
  .por_n   (por_n),
  .tms     (tms),
  .state   (state),
  .ir_q    (ir_q),
  .out_hiz (out_hiz),
  .tdo_oe  (tdo_oe)
);

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;

  localparam int          BSR_W   = 70;
  localparam logic [3:0]  ID_REV  = 4'h2;
  localparam logic [9:0]  ID_CFG  = 10'h0C5;
  localparam logic [5:0]  ID_VEND = 6'h00;
  localparam logic [10:0] ID_MFR  = 11'h04E;
  localparam logic [31:0] ID_EXP  = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

  localparam logic [71:0] PAT    = 72'hA5_3C96_0FF0_1234_ABCF;
  localparam logic [69:0] PINS_A = 70'h2A_DEAD_BEEF_0123_4567;
  localparam logic [69:0] PINS_B = 70'h15_7777_0000_FFFF_1357;

  // {opcode, kind (0 sample reg, 1 id, 2 bypass), hiz}
  localparam logic [5:0] VEC [8] = '{
    {3'b011, 2'd2, 1'b0},
    {3'b101, 2'd2, 1'b0},
    {3'b000, 2'd0, 1'b1},
    {3'b001, 2'd1, 1'b0},
    {3'b010, 2'd0, 1'b1},
    {3'b100, 2'd0, 1'b0},
    {3'b110, 2'd2, 1'b0},
    {3'b111, 2'd2, 1'b0}
  };

  logic             tck = 1'b0;
  logic             por_n = 1'b0;
  logic             tms = 1'b1;
  logic             tdi = 1'b1;
  logic [BSR_W-1:0] pin_cap = PINS_A;
  wire              tdo, tdo_oe, out_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 tck = ~tck;

  scan_tap #(
    .BSR_W(BSR_W), .ID_REV(ID_REV), .ID_CFG(ID_CFG), .ID_VEND(ID_VEND), .ID_MFR(ID_MFR)
  ) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_cap(pin_cap),
    .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_seg(input int lo, input int hi, input logic [71:0] din,
                           inout logic [71:0] dout, inout logic oe_ok);
    for (int i = lo; i <= hi; i++) begin
      dout[i] = tdo;
      oe_ok   = oe_ok & tdo_oe;
      step(i == hi, din[i]);
    end
  endtask

  task automatic run_dr(input int n, input logic [71:0] din,
                        output logic [71:0] dout, output logic oe_ok);
    dout  = '0;
    oe_ok = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    shift_seg(0, n - 1, din, dout, oe_ok);
    step(1, 0); step(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap, output logic hiz_pre);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    hiz_pre = out_hiz;
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [71:0] exp_out(input int kind, input logic [69:0] pins);
    case (kind)
      0:       exp_out = {PAT[1:0], pins};
      1:       exp_out = {PAT[39:0], ID_EXP};
      default: exp_out = {PAT[70:0], 1'b0};
    endcase
  endfunction

  initial begin
    logic [71:0] o;
    logic        oe;
    logic [2:0]  cap;
    logic        hp;
    logic        last_hiz;

    repeat (3) @(posedge tck);
    @(negedge tck);
    por_n = 1'b1;
    #1;
    chk("R1 tdo_oe after power-up", tdo_oe, 0);
    chk("R1 out_hiz after power-up", out_hiz, 0);
    step(0, 0);

    run_dr(72, PAT, o, oe);
    chk("R1 R6 identification word after power-up", o, exp_out(1, PINS_A));
    chk("R9 tdo_oe held during shift", oe, 1);
    chk("R9 tdo_oe low in Run-Test/Idle", tdo_oe, 0);

    last_hiz = 1'b0;
    for (int e = 0; e < 8; e++) begin
      load_ir(VEC[e][5:3], cap, hp);
      chk("R3 capture pattern", cap, 3'b001);
      chk("R4 opcode not active before Update-IR", hp, last_hiz);
      chk("R5 out_hiz for opcode", out_hiz, VEC[e][0]);
      run_dr(72, PAT, o, oe);
      chk("R4 R6 R7 R8 selected register image", o, exp_out(int'(VEC[e][2:1]), PINS_A));
      last_hiz = VEC[e][0];
    end

    // pause in the middle of a sampling scan, with pins changing
    load_ir(3'b100, cap, hp);
    step(1, 0); step(0, 0); step(0, 0);
    o = '0; oe = 1'b1;
    shift_seg(0, 9, PAT, o, oe);
    step(0, 0);
    pin_cap = PINS_B;
    step(0, 0);
    step(1, 0);
    step(0, 0);
    shift_seg(10, 71, PAT, o, oe);
    step(1, 0); step(0, 0);
    chk("R10 R8 scan resumes after pause, pins ignored", o, exp_out(0, PINS_A));
    run_dr(72, PAT, o, oe);
    chk("R8 next capture sees new pins", o, exp_out(0, PINS_B));

    // tdo moves on the falling edge only
    load_ir(3'b111, cap, hp);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R7 bypass captured as 0", tdo, 0);
    tms = 1'b0;
    tdi = 1'b1;
    @(posedge tck);
    #1;
    chk("R9 tdo unchanged after rising edge", tdo, 0);
    @(negedge tck);
    #1;
    chk("R9 tdo updated at falling edge", tdo, 1);

    // high-impedance instruction cleared by five ones plus a reset cycle
    step(1, 0); step(1, 0); step(0, 0);
    load_ir(3'b000, cap, hp);
    chk("R5 out_hiz set by high-impedance sample", out_hiz, 1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 6; k++) step(1, 0);
    chk("R2 out_hiz cleared in Test-Logic-Reset", out_hiz, 0);
    chk("R2 tdo_oe low in Test-Logic-Reset", tdo_oe, 0);
    step(0, 0);
    run_dr(72, PAT, o, oe);
    chk("R2 IDCODE restored after reset", o, exp_out(1, PINS_B));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule